// File: doc/BRIEF.md
# Serial Receive FIFO with Trigger Flags

This block is the receive buffer of a FIFO-backed serial port. Bytes already deframed by the line receiver arrive one per cycle on a valid/data pair and are queued in a 16-entry first-in first-out store. Software drains the queue through a small register port, where reading the data address pops the oldest byte.

Two independent thresholds in the control register shape the flags. One, the trigger level, decides when the status register reports "receive full" in place of "data ready". The other, the accept limit, drives a ready output back toward the line receiver, telling it whether more bytes are welcome. A byte that arrives with all 16 entries occupied is discarded and latched as an overrun in a line status register that clears itself when read.

Top module: `rx_fifo_flags`

## Requirements
- R1: Accepted bytes are returned by data reads in arrival order; up to 16 are held, and the storage indices wrap so order holds across any number of fill and drain rounds.
- R2: A byte arriving while 16 bytes are held (and no pop in that cycle) is discarded, the held bytes are unchanged, and line status bit 0 (overrun) becomes 1.
- R3: Control bits [8:7] choose the trigger level (0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14); status bit 1 (receive full) is 1 exactly when the held count is at or above it.
- R4: Status bit 0 (data ready) is 1 exactly when the held count is nonzero and below the trigger level.
- R5: Control bits [11:9] choose the accept limit from 15, 1, 4, 6, 8, 10, 12, 14 for codes 0 through 7; rx_ready is 1 exactly when the held count is strictly below it.
- R6: A read of the line status address returns its current value and clears it; an overrun occurring in that same cycle leaves the bit set.
- R7: After reset the status register reads 0x0060 (bits 6 and 5 are constant ones), the control and line status registers read 0, the FIFO is empty and rx_ready is 1.
- R8: A byte arriving in the same cycle as a pop is accepted and the count is unchanged, also when 16 bytes are held, in which case no overrun is flagged.
- R9: A data read on an empty FIFO returns 0 and changes nothing.
- R10: Register addresses: 0 data (read pops), 1 control (read/write, 16 bits), 2 status (read only), 3 line status; reg_rdata shows the addressed value combinationally in the cycle of the read, and writes to addresses 0, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Held count is below the accept limit |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
Every one of the 32 combinations of trigger code and accept code is swept with the FIFO filled one byte at a time from empty to full, so each count is compared against both thresholds and an off-by-one in either decode or comparison shows at its exact count. Each full FIFO is then pushed once more and drained, with byte values offset per configuration so that read order, index wrap and overrun retention are separated. Further patterns combine a push with a pop at full, an overrun in the same cycle as a line status read, and pops on an empty FIFO, which distinguish the priority rules from plain push and pop behaviour.

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, trig, limit;
  logic [15:0]   ctrl;
  logic          ovr;

  wire empty    = (cnt == '0);
  wire full_mem = (cnt == CW'(DEPTH));
  wire rd_data  = reg_rd && (reg_addr == 2'd0);
  wire rd_line  = reg_rd && (reg_addr == 2'd3);
  wire pop      = rd_data && !empty;
  wire push     = rx_valid && (!full_mem || pop);
  wire drop     = rx_valid && full_mem && !pop;

  always_comb begin
    case (ctrl[8:7])
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(4);
      2'd2:    trig = CW'(8);
      default: trig = CW'(14);
    endcase
    case (ctrl[11:9])
      3'd0:    limit = CW'(15);
      3'd1:    limit = CW'(1);
      default: limit = CW'({ctrl[11:9], 1'b0});
    endcase
  end

  wire rx_full = (cnt >= trig);
  wire d_ready = !rx_full && !empty;
  assign rx_ready = (cnt < limit);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = empty ? 16'h0 : 16'(mem[rp]);
      2'd1:    reg_rdata = ctrl;
      2'd2:    reg_rdata = 16'h0060 | {14'h0, rx_full, d_ready};
      default: reg_rdata = {15'h0, ovr};
    endcase
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ctrl <= '0;
      ovr  <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (reg_wr && reg_addr == 2'd1) ctrl <= reg_wdata;
      if (drop)         ovr <= 1'b1;
      else if (rd_line) ovr <= 1'b0;
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R2
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr && $stable(cnt) && $stable(wp));

  // R8
  both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pop) |=> $stable(cnt) && !$rose(ovr));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && empty && !rx_valid) |=> empty && $stable(rp));

  // R6
  line_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_line && !drop) |=> !ovr);
endmodule

// File: tb/rx_fifo_flags_tb_top.sv
module rx_fifo_flags_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, reg_rd = 0, reg_wr = 0;
  logic [7:0]  rx_data = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic        rx_ready;
  logic [15:0] reg_rdata;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_flags dut_i (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  function automatic int trig_of(int t);
    return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
  endfunction
  function automatic int lim_of(int l);
    return (l == 0) ? 15 : (l == 1) ? 1 : 2 * l;
  endfunction

  task automatic check_flags(int n, int t, int l);
    logic [15:0] v;
    int tr;
    tr = trig_of(t);
    rd(2'd2, v);
    check("R3", int'(v[1]), int'(n >= tr));
    check("R4", int'(v[0]), int'(n != 0 && n < tr));
    check("R5", int'(rx_ready), int'(n < lim_of(l)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R7 ready", int'(rx_ready), 1);
    rd(2'd2, v); check("R7 status", int'(v), 16'h0060);
    rd(2'd1, v); check("R7 ctrl", int'(v), 0);
    rd(2'd3, v); check("R7 line", int'(v), 0);

    // R9: pop on empty
    rd(2'd0, v); check("R9 data", int'(v), 0);
    rd(2'd2, v); check("R9 status", int'(v), 16'h0060);
    push(8'hA5);
    rd(2'd0, v); check("R9 order", int'(v), 8'hA5);
    rd(2'd0, v); check("R9 data2", int'(v), 0);

    // R10: writes to other addresses are ignored
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'hFFFF); wr(2'd0, 16'hFFFF);
    rd(2'd2, v); check("R10 status", int'(v), 16'h0060);
    rd(2'd3, v); check("R10 line", int'(v), 0);
    rd(2'd0, v); check("R10 data", int'(v), 0);

    base = 8'h10;
    for (int t = 0; t < 4; t++) begin
      for (int l = 0; l < 8; l++) begin
        wr(2'd1, 16'((l << 9) | (t << 7)));
        rd(2'd1, v); check("R10 ctrl", int'(v), (l << 9) | (t << 7));
        for (int n = 0; n < 16; n++) begin
          check_flags(n, t, l);
          push(8'(base + n));
        end
        check_flags(16, t, l);
        push(8'hEE);  // R2 overrun
        check_flags(16, t, l);
        rd(2'd3, v); check("R2 ovr", int'(v), 1);
        rd(2'd3, v); check("R6 cleared", int'(v), 0);
        for (int n = 0; n < 16; n++) begin
          rd(2'd0, v); check("R1 order", int'(v), int'(8'(base + n)));
        end
        check_flags(0, t, l);
        base = base + 8'd37;
      end
    end

    // R8: push with pop at full
    wr(2'd1, 16'h0);
    for (int n = 0; n < 16; n++) push(8'(n));
    @(negedge clk); rx_valid = 1; rx_data = 8'h77; reg_rd = 1; reg_addr = 2'd0;
    #1 check("R8 popped", int'(reg_rdata), 0);
    @(negedge clk); rx_valid = 0; reg_rd = 0;
    rd(2'd3, v); check("R8 no ovr", int'(v), 0);
    check_flags(16, 0, 0);
    for (int n = 1; n < 16; n++) begin
      rd(2'd0, v); check("R8 order", int'(v), n);
    end
    rd(2'd0, v); check("R8 last", int'(v), 8'h77);

    // R6: overrun in the same cycle as line status read
    for (int n = 0; n < 16; n++) push(8'(n));
    @(negedge clk); rx_valid = 1; rx_data = 8'h99; reg_rd = 1; reg_addr = 2'd3;
    #1 check("R6 old", int'(reg_rdata), 0);
    @(negedge clk); rx_valid = 0; reg_rd = 0;
    rd(2'd3, v); check("R6 kept", int'(v), 1);
    rd(2'd3, v); check("R6 clear", int'(v), 0);
    for (int n = 0; n < 16; n++) begin
      rd(2'd0, v); check("R2 contents", int'(v), n);
    end
    rd(2'd0, v); check("R9 after", int'(v), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule